// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block watches the protection flags of a three-phase gate-driver controller and decides whether the gate drivers may run. It receives an active-low sleep request and a set of status flags from analog circuits: supply undervoltage, overtemperature, one drain-source overcurrent comparator per phase and one low-side shunt overcurrent comparator. It also receives a strobe per phase that marks each switching edge of that phase's outputs. It returns a global gate-disable, a ready signal that tells the PWM generator when commands may be accepted, a one-cycle logic-reset pulse, and an active-low fault line with its output-enable, which models an open-drain pin.

Each flag first passes through a two-flop synchroniser. After a switching edge the drain-source comparator of that phase is ignored for a fixed number of cycles, so that recovery spikes cannot trip the protection. Any overcurrent, shunt or overtemperature trip puts the block into a fault state that keeps the gates off. Only a sleep cycle or an undervoltage event clears it. Undervoltage itself is never latched: once the flag drops, the block repeats its wake-up delay and resumes.

Top module: `motor_fault_supervisor`

## Requirements
- R1: After reset the block is asleep: gateOff=1, pwmReady=0, faultOe=0, faultN=1, logicRst=0.
- R2: Every flag input (sleepN, uvFlag, otFlag, shuntOc, dsOc) goes through two flip-flops. A value applied before clock edge k first acts at edge k+2. The swEdge strobes are synchronous and act at once.
- R3: When sleepN goes high and stays high, with no fault and no undervoltage, pwmReady rises and gateOff falls exactly WAKE_CYC+3 clock edges after the first edge that samples sleepN high.
- R4: While the synchronised sleepN is low: gateOff=1, pwmReady=0 and faultOe=0. No flag or strobe received during sleep leaves any latched effect.
- R5: dsOc[i] is ignored in the cycle its swEdge[i] is sampled and in the BLANK_CYC cycles that follow. A synchronised dsOc[i] sample that is high in any other cycle, during wake-up or run, sets the fault.
- R6: A single high synchronised sample of otFlag or shuntOc during wake-up or run sets the fault. No switching edge blanks these two flags.
- R7: In fault: gateOff=1, pwmReady=0, faultN=0, faultOe=1. The fault holds after every flag returns low, for as long as sleepN stays high and uvFlag stays low.
- R8: Driving sleepN low clears a fault. When sleepN returns high, the full wake-up delay of R3 runs again.
- R9: A high synchronised uvFlag forces gateOff=1 and clears any fault and any wake-up progress. When the flag drops with sleepN high, pwmReady returns WAKE_CYC+3 edges after the first edge that samples uvFlag low.
- R10: logicRst is high for exactly one cycle when the block enters sleep or undervoltage from wake-up, run or fault. It is not raised when the block moves from undervoltage to sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleepN | input | 1 | Sleep request, low = sleep (asynchronous) |
| uvFlag | input | 1 | Supply undervoltage flag, high = low supply (asynchronous) |
| otFlag | input | 1 | Overtemperature flag (asynchronous) |
| shuntOc | input | 1 | Low-side shunt overcurrent flag (asynchronous) |
| dsOc | input | NPH | Per-phase drain-source overcurrent flags (asynchronous) |
| swEdge | input | NPH | Per-phase switching-edge strobe (synchronous) |
| gateOff | output | 1 | Global gate disable |
| pwmReady | output | 1 | PWM commands may be accepted |
| logicRst | output | 1 | One-cycle reset pulse for downstream logic |
| faultN | output | 1 | Fault line value, low when a fault is latched |
| faultOe | output | 1 | Fault line enable, high while the line is pulled low |

## Verification
The bench probes both edges of the blanking window. A drain-source flag that is still high in the last blanked cycle must not trip the block, and the same flag held one cycle longer must trip it. A window that is one cycle too short, or one that is also applied to the shunt flag, shows up at once. The wake-up delay is counted edge by edge after sleep and after undervoltage, so a missing synchroniser stage or a wake counter that is off by one gives the wrong count. The bench also checks that a fault stays latched after every flag has returned low, that flags received during sleep leave nothing behind, and that the reset pulse lasts exactly one cycle; a design that missed any of these would keep the gates off, release them too early, or pulse the reset for the wrong length.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  // Supervisor state: quiet states hold everything idle.
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_UVLO  = 3'd1,
    ST_WAKE  = 3'd2,
    ST_RUN   = 3'd3,
    ST_FAULT = 3'd4
  } supState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic quiet;      // clear blanking and wake counters
    logic wakeCount;  // advance the wake-up counter
  } dpCtrl_t;

  // Status from datapath to control.
  typedef struct packed {
    logic wakeDone;   // last cycle of the wake-up delay
    logic faultHit;   // qualified trip condition this cycle
  } dpStat_t;

endpackage

// File: rtl/mfs_sync.sv
module mfs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

endmodule

// File: rtl/mfs_datapath.sv
module mfs_datapath
  import mfs_pkg::*;
#(
  parameter int NPH       = 3,
  parameter int WAKE_CYC  = 200000,
  parameter int BLANK_CYC = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  dpCtrl_t        ctrl,
  input  logic [NPH-1:0] swEdge,
  input  logic [NPH-1:0] dsS,
  input  logic           shuntS,
  input  logic           otS,
  output dpStat_t        stat
);

  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC - 1);
  localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYC);

  // Wake-up delay counter
  logic [WW-1:0] wakeCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wakeCnt <= '0;
    else if (ctrl.quiet || !ctrl.wakeCount)
      wakeCnt <= '0;
    else if (wakeCnt != WAKE_LAST)
      wakeCnt <= wakeCnt + 1'b1;
  end

  assign stat.wakeDone = ctrl.wakeCount && (wakeCnt == WAKE_LAST);

  assert_wake_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wakeCnt <= WAKE_LAST);

  // Per-phase blanking of the drain-source monitors
  logic [NPH-1:0] ocHit;

  for (genvar g = 0; g < NPH; g++) begin : gPhase
    logic [BW-1:0] blankCnt;
    logic          blanked;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        blankCnt <= '0;
      else if (ctrl.quiet)
        blankCnt <= '0;
      else if (swEdge[g])
        blankCnt <= BLANK_LOAD;
      else if (blankCnt != '0)
        blankCnt <= blankCnt - 1'b1;
    end

    assign blanked  = swEdge[g] || (blankCnt != '0);
    assign ocHit[g] = dsS[g] && !blanked;

    // A flag seen in the cycle after an edge can never trip.
    assert_edge_blanks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (swEdge[g] && !ctrl.quiet) |=> !ocHit[g]);
  end

  assign stat.faultHit = otS || shuntS || (|ocHit);

endmodule

// File: rtl/mfs_control.sv
module mfs_control
  import mfs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sleepS,
  input  logic    uvS,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    gateOff,
  output logic    pwmReady,
  output logic    logicRst,
  output logic    faultN,
  output logic    faultOe
);

  supState_t state, nextState;

  function automatic logic isQuiet(supState_t s);
    return (s == ST_SLEEP) || (s == ST_UVLO);
  endfunction

  always_comb begin
    nextState = state;
    if (uvS)
      nextState = ST_UVLO;
    else if (!sleepS)
      nextState = ST_SLEEP;
    else begin
      case (state)
        ST_SLEEP, ST_UVLO: nextState = ST_WAKE;
        ST_WAKE: begin
          if (stat.faultHit)      nextState = ST_FAULT;
          else if (stat.wakeDone) nextState = ST_RUN;
        end
        ST_RUN:   if (stat.faultHit) nextState = ST_FAULT;
        ST_FAULT: nextState = ST_FAULT;
        default:  nextState = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SLEEP;
      logicRst <= 1'b0;
    end else begin
      state    <= nextState;
      logicRst <= isQuiet(nextState) && !isQuiet(state);
    end
  end

  assign ctrl.quiet     = isQuiet(state);
  assign ctrl.wakeCount = (state == ST_WAKE);
  assign gateOff        = (state != ST_RUN);
  assign pwmReady       = (state == ST_RUN);
  assign faultOe        = (state == ST_FAULT);
  assign faultN         = !faultOe;

  assert_sleep_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sleepS |=> (gateOff && !pwmReady && !faultOe));

  assert_uv_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uvS |=> (gateOff && !faultOe));

  assert_fault_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (faultOe && sleepS && !uvS) |=> faultOe);

  assert_ready_after_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwmReady) |-> $past(stat.wakeDone));

  assert_rst_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    logicRst |=> !logicRst);

endmodule

// File: rtl/motor_fault_supervisor.sv
module motor_fault_supervisor
  import mfs_pkg::*;
#(
  parameter int NPH       = 3,
  parameter int WAKE_CYC  = 200000,
  parameter int BLANK_CYC = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sleepN,
  input  logic           uvFlag,
  input  logic           otFlag,
  input  logic           shuntOc,
  input  logic [NPH-1:0] dsOc,
  input  logic [NPH-1:0] swEdge,
  output logic           gateOff,
  output logic           pwmReady,
  output logic           logicRst,
  output logic           faultN,
  output logic           faultOe
);

  localparam int SW = NPH + 4;

  logic [SW-1:0] rawFlags, syncFlags;
  logic          sleepS, uvS, otS, shuntS;
  logic [NPH-1:0] dsS;
  dpCtrl_t       ctrl;
  dpStat_t       stat;

  assign rawFlags = {sleepN, uvFlag, otFlag, shuntOc, dsOc};
  assign {sleepS, uvS, otS, shuntS, dsS} = syncFlags;

  mfs_sync #(.W(SW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rawFlags),
    .dout (syncFlags)
  );

  mfs_datapath #(
    .NPH      (NPH),
    .WAKE_CYC (WAKE_CYC),
    .BLANK_CYC(BLANK_CYC)
  ) u_datapath (
    .clk   (clk),
    .rst_n (rst_n),
    .ctrl  (ctrl),
    .swEdge(swEdge),
    .dsS   (dsS),
    .shuntS(shuntS),
    .otS   (otS),
    .stat  (stat)
  );

  mfs_control u_control (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleepS  (sleepS),
    .uvS     (uvS),
    .stat    (stat),
    .ctrl    (ctrl),
    .gateOff (gateOff),
    .pwmReady(pwmReady),
    .logicRst(logicRst),
    .faultN  (faultN),
    .faultOe (faultOe)
  );

endmodule

// File: tb/motor_fault_supervisor_bench.sv
module motor_fault_supervisor_bench;

  localparam int NPH   = 3;
  localparam int WAKE  = 40;
  localparam int BLANK = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleepN = 1'b0, uvFlag = 1'b0, otFlag = 1'b0, shuntOc = 1'b0;
  logic [NPH-1:0] dsOc = '0, swEdge = '0;
  logic gateOff, pwmReady, logicRst, faultN, faultOe;

  always #2.5 clk = ~clk;  // 200 MHz

  motor_fault_supervisor #(.NPH(NPH), .WAKE_CYC(WAKE), .BLANK_CYC(BLANK)) u_motor_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .sleepN(sleepN), .uvFlag(uvFlag), .otFlag(otFlag),
    .shuntOc(shuntOc), .dsOc(dsOc), .swEdge(swEdge), .gateOff(gateOff),
    .pwmReady(pwmReady), .logicRst(logicRst), .faultN(faultN), .faultOe(faultOe)
  );

  int errors = 0;
  int checks = 0;
  string curReq = "R1";
  bit modelOn = 0;

  // Behavioural reference: 0 asleep, 1 undervoltage, 2 waking, 3 running, 4 faulted
  int mSt = 0;
  int mWake = 0;
  int mBlank[NPH];
  bit mRst = 0;
  bit dly1[$];  // unused placeholder queue kept empty
  logic [NPH+3:0] hist1 = '0, hist2 = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mSt = 0; mWake = 0; mRst = 0; hist1 = '0; hist2 = '0;
      foreach (mBlank[i]) mBlank[i] = 0;
    end else begin
      bit sOk, uLow, trip;
      int nxt;
      sOk  = hist2[NPH+3];
      uLow = hist2[NPH+2];
      trip = hist2[NPH+1] | hist2[NPH];
      for (int i = 0; i < NPH; i++)
        if (hist2[i] && mBlank[i] == 0 && !swEdge[i]) trip = 1;
      if (uLow) nxt = 1;
      else if (!sOk) nxt = 0;
      else if (mSt <= 1) nxt = 2;
      else if (mSt == 2) nxt = trip ? 4 : (mWake == WAKE - 1 ? 3 : 2);
      else if (mSt == 3) nxt = trip ? 4 : 3;
      else nxt = 4;
      mRst = (nxt <= 1) && (mSt > 1);
      for (int i = 0; i < NPH; i++) begin
        if (mSt <= 1) mBlank[i] = 0;
        else if (swEdge[i]) mBlank[i] = BLANK;
        else if (mBlank[i] > 0) mBlank[i]--;
      end
      mWake = (mSt == 2) ? mWake + 1 : 0;
      mSt = nxt;
      hist2 = hist1;
      hist1 = {sleepN, uvFlag, otFlag, shuntOc, dsOc};
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn) begin
      chk(gateOff == (mSt != 3), curReq, "gateOff", gateOff, mSt != 3);
      chk(pwmReady == (mSt == 3), curReq, "pwmReady", pwmReady, mSt == 3);
      chk(faultOe == (mSt == 4), curReq, "faultOe", faultOe, mSt == 4);
      chk(faultN == (mSt != 4), curReq, "faultN", faultN, mSt != 4);
      chk(logicRst == mRst, curReq, "logicRst", logicRst, mRst);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Raise sleepN (or drop uvFlag) beforehand; returns edges until pwmReady.
  task automatic waitReady(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pwmReady && n < 500);
  endtask

  task automatic sleepCycle;
    sleepN = 1'b0;
    tick(6);
    sleepN = 1'b1;
  endtask

  initial begin
    int n;
    tick(3);
    // R1 reset state
    chk(gateOff && !pwmReady && !faultOe && faultN && !logicRst, "R1", "idle outputs",
        {gateOff, pwmReady, faultOe, faultN, logicRst}, 5'b10010);
    rst_n = 1'b1;
    modelOn = 1;
    tick(2);

    // R4 flags and strobes during sleep leave nothing behind
    curReq = "R4";
    otFlag = 1; shuntOc = 1; dsOc = '1; swEdge = '1;
    tick(5);
    chk(gateOff && !faultOe && !logicRst, "R4", "sleep ignores flags", faultOe, 0);
    otFlag = 0; shuntOc = 0; dsOc = '0; swEdge = '0;
    tick(3);

    // R3 wake delay count
    curReq = "R3";
    sleepN = 1'b1;
    waitReady(n);
    chk(n == WAKE + 3, "R3", "wake edges", n, WAKE + 3);
    chk(!faultOe, "R4", "no fault left from sleep", faultOe, 0);
    tick(3);

    // R5 flag confined to the blanking window: no trip
    curReq = "R5";
    dsOc[0] = 1; tick(2); swEdge[0] = 1; tick(1); swEdge[0] = 0; tick(4); dsOc[0] = 0;
    tick(6);
    chk(!faultOe, "R5", "blanked flag ignored", faultOe, 0);
    chk(pwmReady, "R5", "still running", pwmReady, 1);
    // R5 one cycle longer: trips
    dsOc[2] = 1; tick(2); swEdge[2] = 1; tick(1); swEdge[2] = 0; tick(5); dsOc[2] = 0;
    tick(4);
    chk(faultOe && !faultN, "R5", "flag after window trips", faultOe, 1);

    // R7 fault holds with all flags low
    curReq = "R7";
    tick(20);
    chk(faultOe && gateOff && !pwmReady, "R7", "fault latched", faultOe, 1);

    // R8 / R10 sleep clears fault, single reset pulse
    curReq = "R8";
    sleepN = 1'b0;
    tick(3);
    chk(logicRst == 1, "R10", "reset pulse on sleep", logicRst, 1);
    tick(1);
    chk(logicRst == 0, "R10", "reset pulse length", logicRst, 0);
    chk(!faultOe, "R8", "fault cleared by sleep", faultOe, 0);
    tick(3);
    sleepN = 1'b1;
    waitReady(n);
    chk(n == WAKE + 3, "R8", "rewake edges", n, WAKE + 3);

    // R2 synchroniser latency on overtemperature, R6 single sample trips
    curReq = "R6";
    otFlag = 1; tick(1); otFlag = 0;
    tick(1);
    chk(!faultOe, "R2", "no effect before two flops", faultOe, 0);
    tick(1);
    chk(faultOe, "R6", "overtemperature trips", faultOe, 1);

    // R9 undervoltage clears fault and restarts wake
    curReq = "R9";
    tick(5);
    uvFlag = 1;
    tick(3);
    chk(logicRst && !faultOe && gateOff, "R9", "undervoltage resets", faultOe, 0);
    tick(10);
    uvFlag = 0;
    waitReady(n);
    chk(n == WAKE + 3, "R9", "resume edges", n, WAKE + 3);

    // R6 shunt not blanked by a switching edge
    curReq = "R6";
    tick(2);
    swEdge = '1; shuntOc = 1; tick(1); swEdge = '0; shuntOc = 0;
    tick(4);
    chk(faultOe, "R6", "shunt trips during blanking", faultOe, 1);

    // R6 shunt during wake-up; R10 no pulse for undervoltage to sleep
    curReq = "R10";
    uvFlag = 1; tick(4); sleepN = 0; tick(1); uvFlag = 0; tick(5);
    chk(!logicRst, "R10", "no pulse undervoltage to sleep", logicRst, 0);
    curReq = "R6";
    sleepN = 1; tick(10);
    shuntOc = 1; tick(1); shuntOc = 0;
    tick(4);
    chk(faultOe, "R6", "shunt trips in wake", faultOe, 1);
    tick(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule